// File: doc/BRIEF.md
# Head Load Settle Timer with Shared Clock Output

This block drives one output pin that serves two roles, picked by a controller-type select. In timer mode the pin tells a disk controller that the read/write head has settled: once the head load request goes high and stays high, the pin rises after a fixed delay. The delay is longer for the small-drive setting than for the large-drive setting, and an active-low test input cuts it to a small fraction so a bench or production test does not wait for the full count.

In clock mode the same pin carries a square-wave master clock for the disk controller. It is the block clock divided by 2, 4 or 8, chosen by the drive-size and density selects. In this mode the head load request has no effect and the timer is held cleared. The timer is retriggerable: whenever the request drops, the output drops with it in the same cycle, and a fresh request counts the delay from the start.

Top module: `head_load_timer`

## Requirements
- R1: In timer mode (`ctl_mode`=0) with `test_n`=1, `settle_out` rises exactly N clock edges after the first edge that samples `load_req` high, where N = base × PRESCALE, base being 512 when `size_large`=0 and 256 when `size_large`=1 (PRESCALE defaults to 4).
- R2: With `test_n`=0, the base count of R1 is divided by 64 (shifted right by TEST_SHIFT=6), so N is 8×PRESCALE for `size_large`=0 and 4×PRESCALE for `size_large`=1.
- R3: In timer mode `settle_out` is low in any cycle where `load_req` is low, with no register between a falling request and the output.
- R4: Dropping `load_req` for any number of cycles and raising it again restarts the delay, so the output rises a full N edges after the new rise.
- R5: In clock mode (`ctl_mode`=1) `settle_out` is a 50% duty square wave of period 2 cycles when `size_large`=1 and `dens_dbl`=1, 4 cycles when exactly one of them is 1, and 8 cycles when both are 0.
- R6: In clock mode `load_req` is ignored and the timer is held cleared; returning to timer mode with `load_req` already high starts a full delay from the first timer-mode edge.
- R7: While `rst_n` is low, `settle_out` is low in both modes.
- R8: In timer mode, once `settle_out` is high it stays high for as long as `load_req` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also the source of the divided master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_mode | input | 1 | 0 selects the head load timer, 1 selects the divided clock |
| size_large | input | 1 | 1 for the large-drive setting, 0 for the small-drive setting |
| dens_dbl | input | 1 | 1 for double density, 0 for single density (clock mode only) |
| test_n | input | 1 | Active-low test input that shortens the delay |
| load_req | input | 1 | Head load request |
| settle_out | output | 1 | Head-settled flag in timer mode, divided clock in clock mode |

## Verification
The settle flag is due N edges after the first edge that samples the request high. The bench drives inputs on falling edges, counts each following rising edge, and samples on the next falling edge, so the count at the first high sample must equal N exactly. Falling with the request is combinational, so that check samples one time step after the drive, before any rising edge. Clock mode is checked by measuring high and low run lengths in whole cycles on falling-edge samples once the wave has been seen to rise, so the divider's phase does not matter.

// File: rtl/hlt_pkg.sv
package hlt_pkg;

    typedef enum logic [1:0] {
        DIV_BY2 = 2'd0,
        DIV_BY4 = 2'd1,
        DIV_BY8 = 2'd2
    } div_sel_e;

    function automatic div_sel_e pick_divider(input logic size_large, input logic dens_dbl);
        if (size_large && dens_dbl)
            return DIV_BY2;
        else if (size_large || dens_dbl)
            return DIV_BY4;
        else
            return DIV_BY8;
    endfunction

endpackage

// File: rtl/hlt_prescale.sv
module hlt_prescale #(
    parameter int PRESCALE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    typedef struct packed {
        logic [PW-1:0] phase;
    } pre_state_t;

    pre_state_t st_d, st_q;

    assign tick = run && (st_q.phase == LAST);

    always_comb begin
        st_d = st_q;
        if (!run || tick)
            st_d.phase = '0;
        else
            st_d.phase = st_q.phase + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end
endmodule

// File: rtl/hlt_delay.sv
module hlt_delay #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  logic [CW-1:0] target,
    output logic          settled
);
    typedef struct packed {
        logic [CW-1:0] count;
        logic          done;
    } dly_state_t;

    dly_state_t st_d, st_q;
    logic [CW:0] count_inc;

    assign count_inc = {1'b0, st_q.count} + 1'b1;
    assign settled   = st_q.done;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d = '0;
        end else if (tick && !st_q.done) begin
            st_d.count = count_inc[CW-1:0];
            if (count_inc >= {1'b0, target})
                st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end
endmodule

// File: rtl/hlt_clkdiv.sv
module hlt_clkdiv
    import hlt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  div_sel_e sel,
    output logic     div_clk
);
    localparam int DW = 3;

    typedef struct packed {
        logic [DW-1:0] phase;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.phase = st_q.phase + 1'b1;
    end

    always_comb begin
        case (sel)
            DIV_BY2: div_clk = st_q.phase[0];
            DIV_BY4: div_clk = st_q.phase[1];
            default: div_clk = st_q.phase[2];
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end
endmodule

// File: rtl/head_load_timer.sv
module head_load_timer
    import hlt_pkg::*;
#(
    parameter int PRESCALE    = 4,
    parameter int SMALL_TICKS = 512,
    parameter int LARGE_TICKS = 256,
    parameter int TEST_SHIFT  = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_mode,
    input  logic size_large,
    input  logic dens_dbl,
    input  logic test_n,
    input  logic load_req,
    output logic settle_out
);
    localparam int MAX_TICKS = (SMALL_TICKS > LARGE_TICKS) ? SMALL_TICKS : LARGE_TICKS;
    localparam int CW        = $clog2(MAX_TICKS + 1);
    localparam logic [CW-1:0] SMALL_T = CW'(SMALL_TICKS);
    localparam logic [CW-1:0] LARGE_T = CW'(LARGE_TICKS);

    logic          run;
    logic          tick;
    logic          settled;
    logic          div_clk;
    logic [CW-1:0] base_ticks;
    logic [CW-1:0] target;
    div_sel_e      sel;

    assign run        = !ctl_mode && load_req;
    assign base_ticks = size_large ? LARGE_T : SMALL_T;
    assign target     = test_n ? base_ticks : (base_ticks >> TEST_SHIFT);
    assign sel        = pick_divider(size_large, dens_dbl);

    hlt_prescale #(.PRESCALE(PRESCALE)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    hlt_delay #(.CW(CW)) u_dly (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .tick    (tick),
        .target  (target),
        .settled (settled)
    );

    hlt_clkdiv u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .div_clk (div_clk)
    );

    assign settle_out = ctl_mode ? div_clk : (settled && load_req);
endmodule

// File: rtl/hlt_checker.sv
module hlt_checker #(
    parameter int PRESCALE    = 4,
    parameter int LARGE_TICKS = 256,
    parameter int TEST_SHIFT  = 6
) (
    input logic clk,
    input logic rst_n,
    input logic ctl_mode,
    input logic size_large,
    input logic dens_dbl,
    input logic load_req,
    input logic settle_out
);
    localparam int MIN_EDGES = (LARGE_TICKS >> TEST_SHIFT) * PRESCALE;
    localparam logic [15:0] SAT = 16'hFFFF;

    logic [15:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            run_cnt <= '0;
        else if (!ctl_mode && load_req)
            run_cnt <= (run_cnt == SAT) ? SAT : run_cnt + 1'b1;
        else
            run_cnt <= '0;
    end

    assert_min_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_mode && settle_out) |-> (run_cnt >= 16'(MIN_EDGES)));

    assert_low_without_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_mode && !load_req) |-> !settle_out);

    assert_restart_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_mode && $rose(load_req)) |-> !settle_out);

    assert_div2_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_mode && size_large && dens_dbl && $past(ctl_mode && size_large && dens_dbl))
        |-> (settle_out != $past(settle_out)));

    assert_hold_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_mode && settle_out) |=> (ctl_mode || !load_req || settle_out));
endmodule

bind head_load_timer hlt_checker #(
    .PRESCALE    (PRESCALE),
    .LARGE_TICKS (LARGE_TICKS),
    .TEST_SHIFT  (TEST_SHIFT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_mode   (ctl_mode),
    .size_large (size_large),
    .dens_dbl   (dens_dbl),
    .load_req   (load_req),
    .settle_out (settle_out)
);

// File: tb/head_load_timer_tb.sv
module head_load_timer_tb;
    localparam int CLK_PERIOD  = 10;
    localparam int PRESCALE    = 4;
    localparam int SMALL_TICKS = 512;
    localparam int LARGE_TICKS = 256;
    localparam int TEST_SHIFT  = 6;
    localparam int NVEC        = 4;

    // vector: {size_large, test_n}, expected edges computed from R1/R2
    localparam logic [1:0] VEC_CFG [NVEC] = '{2'b11, 2'b01, 2'b10, 2'b00};
    localparam int VEC_EXP [NVEC] = '{
        LARGE_TICKS * PRESCALE,
        SMALL_TICKS * PRESCALE,
        (LARGE_TICKS >> TEST_SHIFT) * PRESCALE,
        (SMALL_TICKS >> TEST_SHIFT) * PRESCALE
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_mode = 1'b0;
    logic size_large = 1'b0;
    logic dens_dbl = 1'b0;
    logic test_n = 1'b1;
    logic load_req = 1'b0;
    logic settle_out;

    int n_checks = 0;
    int n_fails = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    head_load_timer #(
        .PRESCALE    (PRESCALE),
        .SMALL_TICKS (SMALL_TICKS),
        .LARGE_TICKS (LARGE_TICKS),
        .TEST_SHIFT  (TEST_SHIFT)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_mode   (ctl_mode),
        .size_large (size_large),
        .dens_dbl   (dens_dbl),
        .test_n     (test_n),
        .load_req   (load_req),
        .settle_out (settle_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // called right after driving load_req high on a falling edge
    task automatic measure(output int k);
        k = 0;
        while (k < 5000) begin
            @(posedge clk);
            @(negedge clk);
            k++;
            if (settle_out) break;
        end
    endtask

    task automatic phase_lengths(output int hi, output int lo);
        hi = 0;
        lo = 0;
        while (settle_out) @(negedge clk);
        while (!settle_out) @(negedge clk);
        while (settle_out && hi < 50) begin hi++; @(negedge clk); end
        while (!settle_out && lo < 50) begin lo++; @(negedge clk); end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        int k;
        int hi;
        int lo;

        // R7: reset holds the output low in both modes
        repeat (3) @(negedge clk);
        check("R7 reset timer mode", int'(settle_out), 0);
        ctl_mode = 1'b1;
        repeat (2) @(negedge clk);
        check("R7 reset clock mode", int'(settle_out), 0);
        ctl_mode = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R2 vector table
        for (int i = 0; i < NVEC; i++) begin
            load_req   = 1'b0;
            size_large = VEC_CFG[i][1];
            test_n     = VEC_CFG[i][0];
            repeat (2) @(negedge clk);
            load_req = 1'b1;
            measure(k);
            check(test_n ? "R1 delay edges" : "R2 test delay edges", k, VEC_EXP[i]);
        end

        // R8: stays high while request held
        repeat (5) @(negedge clk);
        check("R8 held high", int'(settle_out), 1);

        // R3: falls at once with request
        load_req = 1'b0;
        #1;
        check("R3 immediate fall", int'(settle_out), 0);

        // R4: retrigger restarts the delay
        size_large = 1'b1;
        test_n     = 1'b0;
        @(negedge clk);
        load_req = 1'b1;
        repeat (10) @(negedge clk);
        check("R4 low mid-delay", int'(settle_out), 0);
        load_req = 1'b0;
        @(negedge clk);
        load_req = 1'b1;
        measure(k);
        check("R4 full delay after retrigger", k, (LARGE_TICKS >> TEST_SHIFT) * PRESCALE);

        // R5/R6: clock mode with request held high
        ctl_mode   = 1'b1;
        size_large = 1'b1;
        dens_dbl   = 1'b1;
        repeat (3) @(negedge clk);
        phase_lengths(hi, lo);
        check("R5 div2 high", hi, 1);
        check("R5 div2 low", lo, 1);
        dens_dbl = 1'b0;
        phase_lengths(hi, lo);
        check("R5 div4 high", hi, 2);
        check("R5 div4 low", lo, 2);
        size_large = 1'b0;
        phase_lengths(hi, lo);
        check("R5 div8 high", hi, 4);
        check("R5 div8 low", lo, 4);

        // R6: back to timer mode with request already high
        size_large = 1'b1;
        @(negedge clk);
        ctl_mode = 1'b0;
        #1;
        check("R6 timer cleared on return", int'(settle_out), 0);
        measure(k);
        check("R6 full delay after mode switch", k, (LARGE_TICKS >> TEST_SHIFT) * PRESCALE);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule